// File: doc/BRIEF.md
# Phase-Scheduled Switch Forwarding Controller

This block makes the forwarding decision for every frame entering a time-slotted industrial Ethernet switch. A free-running tick counter splits each communication cycle into three windows that always come in the same order: an open window, then a transition window, then a reserved window in which only real-time traffic may reach time-slotted devices. When a frame starts to arrive, the block looks at the current window, the frame's class, its length and whether its egress port leads to a time-slotted device. From these it picks cut-through, store-and-forward, hold or discard.

Held frames are kept as tags in a small arrival-ordered queue. They are handed back one per clock as soon as the reserved window closes, which is also the point where the next cycle begins. The cycle, transition and reserved lengths come in as tick counts (a 1 ms cycle with a 30.5 µs reserved window is 250000 and 7625 ticks at 4 ns). They are captured only at a cycle boundary, so a cycle in progress never changes shape. MAC framing, address lookup, frame storage and time synchronisation are done by other blocks.

Top module: `slot_fwd_ctrl`

## Requirements
- R1: With captured lengths C (cycle), T (transition) and V (reserved), the tick count runs 0..C-1 and wraps. The `phase` output is 0 (open) for counts below C-V-T, 1 (transition) for counts from C-V-T up to C-V-1, and 2 (reserved) for counts from C-V upward.
- R2: A frame arriving in the open window gets mode 0 (cut-through), whatever its class and egress type.
- R3: A frame of L bytes arriving at count c in the transition window gets mode 1 (store-and-forward) when c + 2·L·8·bit-time/tick ≤ C-V. That is the time to receive it fully and then send it, and the send must end no later than the start of the reserved window.
- R4: A transition-window frame that fails the R3 check gets mode 2 (hold).
- R5: A reserved-class frame arriving in the reserved window gets mode 0.
- R6: An ordinary frame arriving in the reserved window whose egress port has a time-slotted device gets mode 2.
- R7: An ordinary frame arriving in the reserved window whose egress port has no time-slotted device gets mode 0.
- R8: Held tags are released in arrival order, one per clock on `relValid`/`relTag`. Release starts the clock after the count wraps and covers exactly the entries queued at the wrap, including a hold decided on the wrap tick itself.
- R9: When the hold queue already holds HQ_DEPTH entries, a frame that would be held gets mode 3 (discard) and is not queued.
- R10: Configuration inputs are captured while reset is asserted and at each wrap only. A change in mid-cycle does not alter the current cycle's windows.
- R11: After reset, `decValid` and `relValid` are 0, the count is 0 and `phase` follows R1 for count 0.
- R12: Every clock with `frmValid` high produces `decValid` high on the next clock, carrying that frame's tag on `decTag` and its mode on `decMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of the cycle counter |
| rstN | input | 1 | Synchronous active-low reset |
| cfgCycle | input | CNT_W | Cycle length in ticks |
| cfgTrans | input | CNT_W | Transition window length in ticks |
| cfgRsv | input | CNT_W | Reserved window length in ticks |
| frmValid | input | 1 | Start of a received frame; one clock per frame |
| frmRsvClass | input | 1 | 1 = reserved real-time class |
| frmSlotted | input | 1 | 1 = egress port has a time-slotted device |
| frmLen | input | LEN_W | Frame length in bytes |
| frmTag | input | TAG_W | Frame handle supplied by the buffer manager |
| phase | output | 2 | Current window: 0 open, 1 transition, 2 reserved |
| decValid | output | 1 | Decision strobe |
| decMode | output | 2 | 0 cut-through, 1 store-and-forward, 2 hold, 3 discard |
| decTag | output | TAG_W | Tag of the decided frame |
| relValid | output | 1 | Release strobe for a held frame |
| relTag | output | TAG_W | Tag of the released frame |

## Verification
The bench sends transition-window frames whose send time ends exactly at the reserved window start, one tick later, and longer frames near the window start. An off-by-one in the fit check would turn the exact fit into a hold, and a check that counted only the receive time would let the longer frame through. A hold decided on the last tick of the cycle must be released with the others; a design that snapshots the queue before that push would strand it for a whole cycle. Nine holds against an eight-deep queue expose overflow or a lost tag. A mid-cycle configuration change shows whether windows move before the boundary.

// File: rtl/slot_fwd_pkg.sv
package slot_fwd_pkg;
  typedef enum logic [1:0] {
    PH_OPEN  = 2'd0,
    PH_TRANS = 2'd1,
    PH_RSV   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    FM_CUT  = 2'd0,
    FM_SNF  = 2'd1,
    FM_HOLD = 2'd2,
    FM_DROP = 2'd3
  } fwd_mode_e;

  // strobes from the decision logic to the timer/queue datapath
  typedef struct packed {
    logic push;
    logic pop;
  } hq_strobe_t;
endpackage

// File: rtl/slot_fwd_datapath.sv
module slot_fwd_datapath
  import slot_fwd_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int TAG_W    = 8,
  parameter int HQ_DEPTH = 8,
  localparam int PTR_W   = $clog2(HQ_DEPTH),
  localparam int FILL_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgCycle,
  input  logic [CNT_W-1:0]  cfgTrans,
  input  logic [CNT_W-1:0]  cfgRsv,
  input  hq_strobe_t        stb,
  input  logic [TAG_W-1:0]  pushTag,
  output phase_e            phaseNow,
  output logic [CNT_W-1:0]  tickCnt,
  output logic [CNT_W-1:0]  rsvStart,
  output logic              wrapNow,
  output logic [FILL_W-1:0] fill,
  output logic [TAG_W-1:0]  headTag
);
  logic [CNT_W-1:0] cycSh, trnSh, rsvSh;
  logic [CNT_W-1:0] trnStart;

  // ---------------- cycle timer ----------------
  assign wrapNow  = (tickCnt == cycSh - CNT_W'(1));
  assign rsvStart = cycSh - rsvSh;
  assign trnStart = rsvStart - trnSh;

  always_comb begin
    if (tickCnt >= rsvStart)      phaseNow = PH_RSV;
    else if (tickCnt >= trnStart) phaseNow = PH_TRANS;
    else                          phaseNow = PH_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      cycSh   <= cfgCycle;
      trnSh   <= cfgTrans;
      rsvSh   <= cfgRsv;
    end else if (wrapNow) begin
      tickCnt <= '0;
      cycSh   <= cfgCycle;
      trnSh   <= cfgTrans;
      rsvSh   <= cfgRsv;
    end else begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  // ---------------- hold queue (tags only) ----------------
  logic [TAG_W-1:0] mem [HQ_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  assign headTag = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= pushTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (stb.pop)  rdPtr <= rdPtr + PTR_W'(1);
      fill <= fill + FILL_W'(stb.push) - FILL_W'(stb.pop);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < cycSh); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_W'(HQ_DEPTH)); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> fill != '0); // R8
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrapNow |=> $stable(cycSh) && $stable(trnSh) && $stable(rsvSh)); // R10
endmodule

// File: rtl/slot_fwd_control.sv
module slot_fwd_control
  import slot_fwd_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int LEN_W    = 11,
  parameter int TAG_W    = 8,
  parameter int HQ_DEPTH = 8,
  parameter int TPB      = 20,
  localparam int PTR_W   = $clog2(HQ_DEPTH),
  localparam int FILL_W  = PTR_W + 1,
  localparam int SUM_W   = CNT_W + LEN_W + $clog2(TPB + 1) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  phase_e            phaseNow,
  input  logic [CNT_W-1:0]  tickCnt,
  input  logic [CNT_W-1:0]  rsvStart,
  input  logic              wrapNow,
  input  logic [FILL_W-1:0] fill,
  input  logic [TAG_W-1:0]  headTag,
  input  logic              frmValid,
  input  logic              frmRsvClass,
  input  logic              frmSlotted,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic [TAG_W-1:0]  frmTag,
  output hq_strobe_t        stb,
  output logic              decValid,
  output fwd_mode_e         decMode,
  output logic [TAG_W-1:0]  decTag,
  output logic              relValid,
  output logic [TAG_W-1:0]  relTag
);
  fwd_mode_e         modeRaw, modeSel;
  logic [SUM_W-1:0]  sendEnd;
  logic              fits, qFull;
  logic [FILL_W-1:0] relLeft, fillNext;

  // time by which receive-then-send would finish
  assign sendEnd = SUM_W'(tickCnt) + SUM_W'(frmLen) * SUM_W'(2 * TPB);
  assign fits    = sendEnd <= SUM_W'(rsvStart);
  assign qFull   = (fill == FILL_W'(HQ_DEPTH));

  always_comb begin
    unique case (phaseNow)
      PH_TRANS: modeRaw = fits ? FM_SNF : FM_HOLD;
      PH_RSV:   modeRaw = (!frmRsvClass && frmSlotted) ? FM_HOLD : FM_CUT;
      default:  modeRaw = FM_CUT;
    endcase
    modeSel = (modeRaw == FM_HOLD && qFull) ? FM_DROP : modeRaw;
  end

  assign stb.push = frmValid && (modeSel == FM_HOLD);
  assign stb.pop  = (relLeft != '0);
  assign fillNext = fill + FILL_W'(stb.push) - FILL_W'(stb.pop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relLeft  <= '0;
      decValid <= 1'b0;
      decMode  <= FM_CUT;
      decTag   <= '0;
      relValid <= 1'b0;
      relTag   <= '0;
    end else begin
      if (wrapNow)      relLeft <= fillNext;
      else if (stb.pop) relLeft <= relLeft - FILL_W'(1);
      decValid <= frmValid;
      if (frmValid) begin
        decMode <= modeSel;
        decTag  <= frmTag;
      end
      relValid <= stb.pop;
      if (stb.pop) relTag <= headTag;
    end
  end

  AST_OPEN_CUT: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && phaseNow == PH_OPEN |=> decMode == FM_CUT); // R2
  AST_RSV_CLASS_CUT: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && frmRsvClass && phaseNow == PH_RSV |=> decMode == FM_CUT); // R5
  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    fill == FILL_W'(HQ_DEPTH) |-> !stb.push); // R9
  AST_DEC_LAT: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> decValid && decTag == $past(frmTag)); // R12
endmodule

// File: rtl/slot_fwd_ctrl.sv
module slot_fwd_ctrl
  import slot_fwd_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int LEN_W    = 11,
  parameter int TAG_W    = 8,
  parameter int HQ_DEPTH = 8,
  parameter int BIT_PS   = 10000,
  parameter int CLK_PS   = 4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgCycle,
  input  logic [CNT_W-1:0] cfgTrans,
  input  logic [CNT_W-1:0] cfgRsv,
  input  logic             frmValid,
  input  logic             frmRsvClass,
  input  logic             frmSlotted,
  input  logic [LEN_W-1:0] frmLen,
  input  logic [TAG_W-1:0] frmTag,
  output logic [1:0]       phase,
  output logic             decValid,
  output logic [1:0]       decMode,
  output logic [TAG_W-1:0] decTag,
  output logic             relValid,
  output logic [TAG_W-1:0] relTag
);
  localparam int TPB    = (8 * BIT_PS) / CLK_PS;  // ticks per byte
  localparam int FILL_W = $clog2(HQ_DEPTH) + 1;

  phase_e            phaseNow;
  fwd_mode_e         modeOut;
  hq_strobe_t        stb;
  logic [CNT_W-1:0]  tickCnt, rsvStart;
  logic              wrapNow;
  logic [FILL_W-1:0] fill;
  logic [TAG_W-1:0]  headTag;

  slot_fwd_datapath #(
    .CNT_W(CNT_W), .TAG_W(TAG_W), .HQ_DEPTH(HQ_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgCycle(cfgCycle), .cfgTrans(cfgTrans), .cfgRsv(cfgRsv),
    .stb(stb), .pushTag(frmTag),
    .phaseNow(phaseNow), .tickCnt(tickCnt), .rsvStart(rsvStart),
    .wrapNow(wrapNow), .fill(fill), .headTag(headTag)
  );

  slot_fwd_control #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .TAG_W(TAG_W),
    .HQ_DEPTH(HQ_DEPTH), .TPB(TPB)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .phaseNow(phaseNow), .tickCnt(tickCnt), .rsvStart(rsvStart),
    .wrapNow(wrapNow), .fill(fill), .headTag(headTag),
    .frmValid(frmValid), .frmRsvClass(frmRsvClass),
    .frmSlotted(frmSlotted), .frmLen(frmLen), .frmTag(frmTag),
    .stb(stb), .decValid(decValid), .decMode(modeOut), .decTag(decTag),
    .relValid(relValid), .relTag(relTag)
  );

  assign phase   = phaseNow;
  assign decMode = modeOut;
endmodule

// File: tb/slot_fwd_ctrl_test.sv
`timescale 1ns/1ps
module slot_fwd_ctrl_test;
  localparam int CNT_W = 20, LEN_W = 11, TAG_W = 8, DEPTH = 8, TPB = 20;

  logic clk = 0, rstN = 0;
  logic [CNT_W-1:0] cfgCycle = 200, cfgTrans = 60, cfgRsv = 40;
  logic frmValid = 0, frmRsvClass = 0, frmSlotted = 0;
  logic [LEN_W-1:0] frmLen = 0;
  logic [TAG_W-1:0] frmTag = 0;
  logic [1:0] phase, decMode;
  logic decValid, relValid;
  logic [TAG_W-1:0] decTag, relTag;

  slot_fwd_ctrl uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit cmpOn = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mcnt, mCyc, mTrn, mRsv, relLeft;
  int q[$];
  int relSeen[$];
  bit expDecV, expRelV;
  int expMode, expDecTag, expRelTag;
  string expReq = "R12";

  function automatic int phaseOf(int c);
    if (c >= mCyc - mRsv) return 2;
    if (c >= mCyc - mRsv - mTrn) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mcnt = 0; mCyc = cfgCycle; mTrn = cfgTrans; mRsv = cfgRsv;
      q.delete(); relLeft = 0; expDecV = 0; expRelV = 0;
    end else begin
      int ph, sizeBefore, mode;
      ph = phaseOf(mcnt);
      sizeBefore = q.size();
      expDecV = frmValid;
      if (frmValid) begin
        if (ph == 0) begin mode = 0; expReq = "R2"; end
        else if (ph == 1) begin
          if (mcnt + 2 * int'(frmLen) * TPB <= mCyc - mRsv) begin mode = 1; expReq = "R3"; end
          else begin mode = 2; expReq = "R4"; end
        end else if (frmRsvClass) begin mode = 0; expReq = "R5"; end
        else if (frmSlotted) begin mode = 2; expReq = "R6"; end
        else begin mode = 0; expReq = "R7"; end
        if (mode == 2 && sizeBefore >= DEPTH) begin mode = 3; expReq = "R9"; end
        expMode = mode; expDecTag = frmTag;
      end
      if (relLeft > 0) begin
        expRelV = 1; expRelTag = q.pop_front(); relLeft--;
      end else expRelV = 0;
      if (frmValid && expMode == 2) q.push_back(frmTag);
      if (mcnt == mCyc - 1) begin
        mcnt = 0; mCyc = cfgCycle; mTrn = cfgTrans; mRsv = cfgRsv;
        relLeft = q.size();
      end else mcnt++;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) if (cmpOn && !finished) begin
    chk(phase == 2'(phaseOf(mcnt)), "R1", phase, phaseOf(mcnt));
    chk(decValid == expDecV, "R12", decValid, expDecV);
    if (expDecV) begin
      chk(decMode == 2'(expMode), expReq, decMode, expMode);
      chk(decTag == TAG_W'(expDecTag), "R12", decTag, expDecTag);
    end
    chk(relValid == expRelV, "R8", relValid, expRelV);
    if (expRelV) chk(relTag == TAG_W'(expRelTag), "R8", relTag, expRelTag);
    if (relValid) relSeen.push_back(relTag);
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitCnt(input int t);
    while (mcnt != t) @(negedge clk);
  endtask

  task automatic sendAt(input int t, input bit cls, input bit slot, input int len,
                        input int tag, input int expM, input string req);
    waitCnt(t);
    frmValid = 1; frmRsvClass = cls; frmSlotted = slot;
    frmLen = LEN_W'(len); frmTag = TAG_W'(tag);
    @(negedge clk);
    frmValid = 0;
    chk(decValid && decMode == 2'(expM) && decTag == TAG_W'(tag), req, decMode, expM);
  endtask

  task automatic report();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmpOn = 1;
    // R11: reset state
    chk(decValid == 0 && relValid == 0, "R11", decValid, 0);
    chk(phase == 2'd0, "R11", phase, 0);
    rstN = 1;
    @(negedge clk);

    // cycle A: open, transition fit/no-fit, reserved cases
    sendAt(10, 0, 1, 64, 8'h01, 0, "R2");
    sendAt(50, 1, 0, 64, 8'h02, 0, "R2");
    sendAt(100, 0, 1, 2, 8'hA1, 2, "R4");   // 100+80 > 160
    sendAt(110, 0, 1, 1, 8'h03, 1, "R3");   // 150 <= 160
    sendAt(120, 0, 0, 1, 8'h04, 1, "R3");   // exactly 160
    sendAt(121, 0, 0, 1, 8'hA2, 2, "R4");   // one tick late
    sendAt(165, 1, 1, 100, 8'h05, 0, "R5");
    sendAt(170, 0, 1, 100, 8'hA3, 2, "R6");
    sendAt(175, 0, 0, 100, 8'h06, 0, "R7");
    relSeen.delete();
    sendAt(199, 0, 1, 64, 8'hA4, 2, "R6");  // hold decided on the wrap tick
    chk(relSeen.size() == 0, "R8", relSeen.size(), 0);
    waitCnt(20);
    chk(relSeen.size() == 4, "R8", relSeen.size(), 4);
    if (relSeen.size() == 4) begin
      chk(relSeen[0] == 8'hA1 && relSeen[1] == 8'hA2, "R8", relSeen[0], 8'hA1);
      chk(relSeen[2] == 8'hA3 && relSeen[3] == 8'hA4, "R8", relSeen[3], 8'hA4);
    end

    // cycle B: fill the queue, ninth hold is discarded
    for (int i = 0; i < 9; i++)
      sendAt(160 + i, 0, 1, 64, 8'hB0 + i, (i < 8) ? 2 : 3, (i < 8) ? "R6" : "R9");
    relSeen.delete();
    waitCnt(20);
    chk(relSeen.size() == 8, "R9", relSeen.size(), 8);
    if (relSeen.size() == 8) begin
      chk(relSeen[0] == 8'hB0, "R8", relSeen[0], 8'hB0);
      chk(relSeen[7] == 8'hB7, "R9", relSeen[7], 8'hB7);
    end

    // cycle C: mid-cycle configuration change
    waitCnt(50);
    cfgCycle = 300; cfgTrans = 80; cfgRsv = 50;
    waitCnt(120);
    chk(phase == 2'd1, "R10", phase, 1);
    sendAt(165, 0, 1, 64, 8'hC1, 2, "R10");  // still reserved under old values
    waitCnt(0);
    waitCnt(160);
    chk(phase == 2'd0, "R10", phase, 0);
    sendAt(175, 0, 1, 1, 8'hC2, 1, "R10");   // new transition: 175+40 <= 250
    sendAt(260, 1, 1, 64, 8'hC3, 0, "R5");
    waitCnt(5);
    report();
  end
endmodule